// File: doc/BRIEF.md
# Instruction Fetch Program Counter Unit

This block owns the program counter at the front of a processor pipeline. It sends fetch commands on a valid/ready command channel, keeps the address of every accepted command in a small ordered queue, and pairs each in-order response with the address it answers. The resulting instruction word, or an access-fault marker, goes to the decode stage. The response path passes through a fixed number of register stages, equal to the minimum bus latency, so the unit can sustain one instruction per cycle.

Any pipeline stage can request a redirect. Each stage has its own request bit and target slot. When several stages request a redirect in the same cycle, the stage with the highest index wins. That stage holds the oldest instruction. After a redirect, every response still owed to the abandoned path is dropped. A counter of outstanding commands, which the redirect turns into a discard count, tracks this.

Two build-time choices shape the timing. The redirect target can reach the fetch address in the same cycle (immediate) or one cycle later through a register (registered). A command that was not accepted can be held fixed until it is accepted (persistent), or it can be changed freely (retractable).

Top module: `fetch_pc_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, with no redirect requested, `cmd_valid` is 1, `cmd_addr` equals `RESET_VEC`, and `out_valid` is 0.
- R2: With no redirect, the program counter advances by 4 after each cycle in which `cmd_valid` and `cmd_ready` are both high. It keeps its value when the command is not accepted.
- R3: In immediate mode, when a redirect is requested and no command is being held, `cmd_addr` shows the winning target in that same cycle.
- R4: In registered mode, `cmd_addr` keeps the current program counter in the redirect cycle and shows the winning target in the following cycle.
- R5: Request bit i of `jmp_valid` selects the target in bits [i*ADDR_W +: ADDR_W] of `jmp_target`. Among simultaneous requests, the highest index wins.
- R6: In persistent mode, a command that was valid and not accepted keeps `cmd_valid` high and `cmd_addr` unchanged until it is accepted, even if a redirect arrives meanwhile. Fetching then continues from that redirect's target.
- R7: In retractable mode, a redirect may replace the address of a command that has not been accepted.
- R8: Responses to commands accepted before a redirect, and any response arriving in the redirect cycle itself, never appear on `out_valid`. The first response after them is delivered with its own fetch address.
- R9: A response that is kept appears on the outputs exactly `LAT_MIN` clock edges after the edge that samples it. It carries the fetch address in `out_pc` and the word in `out_instr`.
- R10: With `CATCH_FAULT` set, a response with `rsp_error` = 1 is delivered with `out_fault` = 1 and `out_instr` = 0. An error-free response gives `out_fault` = 0.
- R11: When `MAX_OUT` accepted commands are still awaiting a response, `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| jmp_valid | input | NUM_STAGES | One redirect request bit per pipeline stage |
| jmp_target | input | NUM_STAGES*ADDR_W | Redirect target per stage, slot i in bits [i*ADDR_W +: ADDR_W] |
| cmd_valid | output | 1 | Fetch command valid |
| cmd_ready | input | 1 | Fetch command accepted by the bus |
| cmd_addr | output | ADDR_W | Fetch address |
| rsp_valid | input | 1 | In-order fetch response valid |
| rsp_error | input | 1 | Response carries an access error |
| rsp_data | input | DATA_W | Fetched instruction word |
| out_valid | output | 1 | Instruction valid toward decode |
| out_pc | output | ADDR_W | Address of the delivered instruction |
| out_instr | output | DATA_W | Delivered instruction word (zero on fault) |
| out_fault | output | 1 | Instruction access fault toward decode |

## Verification
A wrong discard count is visible at the ports within a few cycles. A stale instruction reaches decode one `LAT_MIN` window after the response for the abandoned path. Or, when the count is too high, the first correct-path instruction is silently dropped. A corrupted address queue shows up as `out_pc` disagreeing with the command the response answers. A bad outstanding count either leaves `cmd_valid` low when commands should flow or lets a fifth command out. A wrong hold or redirect state shows at once as `cmd_addr` changing under a pending command, or as fetch resuming at the wrong target on the cycle after acceptance.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    // How a redirect reaches the fetch address
    typedef enum logic {
        JMP_IMMEDIATE  = 1'b0,
        JMP_REGISTERED = 1'b1
    } jmp_mode_e;

    // Whether an unaccepted command may change
    typedef enum logic {
        CMD_RETRACTABLE = 1'b0,
        CMD_PERSISTENT  = 1'b1
    } cmd_mode_e;

    function automatic int unsigned count_width(input int unsigned limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/fetch_jump_arb.sv
module fetch_jump_arb #(
    parameter int unsigned NUM_STAGES = 4,
    parameter int unsigned ADDR_W     = 32
) (
    input  logic [NUM_STAGES-1:0]        req,
    input  logic [NUM_STAGES*ADDR_W-1:0] targets,
    output logic                         any,
    output logic [ADDR_W-1:0]            target
);

    logic [ADDR_W-1:0] slot [NUM_STAGES];

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_slot
        assign slot[s] = targets[s*ADDR_W +: ADDR_W];
    end

    // ascending scan: the last (oldest) requesting stage overwrites earlier ones
    always_comb begin
        any    = 1'b0;
        target = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (req[s]) begin
                any    = 1'b1;
                target = slot[s];
            end
        end
    end

endmodule

// File: rtl/fetch_addr_queue.sv
module fetch_addr_queue #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [ADDR_W-1:0] slots_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.wr = (ptr_q.wr == LAST) ? '0 : ptr_q.wr + 1'b1;
        end
        if (pop) begin
            ptr_d.rd = (ptr_q.rd == LAST) ? '0 : ptr_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots_q[ptr_q.wr] <= push_addr;
        end
    end

    assign head_addr = slots_q[ptr_q.rd];

endmodule

// File: rtl/fetch_rsp_pipe.sv
module fetch_rsp_pipe #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [DATA_W-1:0] in_instr,
    input  logic              in_fault,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_pc,
    output logic [DATA_W-1:0] out_instr,
    output logic              out_fault
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] instr;
        logic              fault;
    } beat_t;

    beat_t head_beat;
    beat_t stg_d [STAGES];
    beat_t stg_q [STAGES];

    assign head_beat = '{valid: in_valid, pc: in_pc, instr: in_instr, fault: in_fault};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb begin
                stg_d[s] = head_beat;
                if (flush) begin
                    stg_d[s].valid = 1'b0;
                end
            end
        end else begin : g_next
            always_comb begin
                stg_d[s] = stg_q[s-1];
                if (flush) begin
                    stg_d[s].valid = 1'b0;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[s] <= '0;
            end else begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign out_valid = stg_q[STAGES-1].valid;
    assign out_pc    = stg_q[STAGES-1].pc;
    assign out_instr = stg_q[STAGES-1].instr;
    assign out_fault = stg_q[STAGES-1].fault;

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       NUM_STAGES  = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 'h0000_1000,
    parameter int unsigned       LAT_MIN     = 1,
    parameter int unsigned       MAX_OUT     = 4,
    parameter jmp_mode_e         JUMP_MODE   = JMP_IMMEDIATE,
    parameter cmd_mode_e         CMD_MODE    = CMD_PERSISTENT,
    parameter bit                CATCH_FAULT = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_STAGES-1:0]        jmp_valid,
    input  logic [NUM_STAGES*ADDR_W-1:0] jmp_target,
    output logic                         cmd_valid,
    input  logic                         cmd_ready,
    output logic [ADDR_W-1:0]            cmd_addr,
    input  logic                         rsp_valid,
    input  logic                         rsp_error,
    input  logic [DATA_W-1:0]            rsp_data,
    output logic                         out_valid,
    output logic [ADDR_W-1:0]            out_pc,
    output logic [DATA_W-1:0]            out_instr,
    output logic                         out_fault
);

    localparam int unsigned       CNT_W     = count_width(MAX_OUT);
    localparam logic [CNT_W-1:0]  CNT_LIMIT = CNT_W'(MAX_OUT);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(4);
    localparam bit                IMMEDIATE = (JUMP_MODE == JMP_IMMEDIATE);
    localparam bit                PERSIST   = (CMD_MODE == CMD_PERSISTENT);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              hold;      // command was offered and not taken
        logic              redir_v;   // redirect waiting behind a held command
        logic [ADDR_W-1:0] redir_pc;
        logic [CNT_W-1:0]  outst;     // accepted, response not yet seen
        logic [CNT_W-1:0]  drop;      // responses still owed to an old path
    } pc_state_t;

    pc_state_t st_d, st_q;

    logic              jmp_any;
    logic [ADDR_W-1:0] jmp_tgt;
    logic [ADDR_W-1:0] q_head;
    logic              held;
    logic              fire;
    logic              fire_old;
    logic              keep_rsp;
    logic              rsp_fault;
    logic [DATA_W-1:0] rsp_word;

    fetch_jump_arb #(
        .NUM_STAGES(NUM_STAGES),
        .ADDR_W    (ADDR_W)
    ) u_arb (
        .req    (jmp_valid),
        .targets(jmp_target),
        .any    (jmp_any),
        .target (jmp_tgt)
    );

    always_comb begin
        st_d = st_q;

        held      = PERSIST && st_q.hold;
        cmd_valid = held || (st_q.outst < CNT_LIMIT);

        if (!held && IMMEDIATE && jmp_any) begin
            cmd_addr = jmp_tgt;
        end else begin
            cmd_addr = st_q.pc;
        end

        fire     = cmd_valid && cmd_ready;
        fire_old = fire && !(!held && IMMEDIATE && jmp_any);

        // program counter and pending redirect
        if (held) begin
            if (fire) begin
                st_d.redir_v = 1'b0;
                if (jmp_any) begin
                    st_d.pc = jmp_tgt;
                end else if (st_q.redir_v) begin
                    st_d.pc = st_q.redir_pc;
                end else begin
                    st_d.pc = st_q.pc + STEP;
                end
            end else if (jmp_any) begin
                st_d.redir_v  = 1'b1;
                st_d.redir_pc = jmp_tgt;
            end
        end else if (IMMEDIATE) begin
            st_d.pc = fire ? cmd_addr + STEP : cmd_addr;
        end else begin
            if (jmp_any) begin
                st_d.pc = jmp_tgt;
            end else if (fire) begin
                st_d.pc = st_q.pc + STEP;
            end
        end

        st_d.hold  = cmd_valid && !cmd_ready;
        st_d.outst = st_q.outst + CNT_W'(fire) - CNT_W'(rsp_valid);

        // responses owed to an abandoned path
        if (jmp_any) begin
            st_d.drop = st_q.outst - CNT_W'(rsp_valid) + CNT_W'(fire_old);
        end else begin
            st_d.drop = st_q.drop
                      - CNT_W'(rsp_valid && (st_q.drop != '0))
                      + CNT_W'(held && st_q.redir_v && fire);
        end

        keep_rsp  = rsp_valid && (st_q.drop == '0) && !jmp_any;
        rsp_fault = CATCH_FAULT && rsp_error;
        rsp_word  = rsp_fault ? '0 : rsp_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pc       <= RESET_VEC;
            st_q.redir_pc <= RESET_VEC;
        end else begin
            st_q <= st_d;
        end
    end

    fetch_addr_queue #(
        .ADDR_W(ADDR_W),
        .DEPTH (MAX_OUT)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fire),
        .push_addr(cmd_addr),
        .pop      (rsp_valid),
        .head_addr(q_head)
    );

    fetch_rsp_pipe #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .STAGES(LAT_MIN)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (jmp_any),
        .in_valid (keep_rsp),
        .in_pc    (q_head),
        .in_instr (rsp_word),
        .in_fault (rsp_fault),
        .out_valid(out_valid),
        .out_pc   (out_pc),
        .out_instr(out_instr),
        .out_fault(out_fault)
    );

endmodule

// File: rtl/fetch_pc_unit_chk.sv
module fetch_pc_unit_chk
    import fetch_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       NUM_STAGES  = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 'h0000_1000,
    parameter int unsigned       MAX_OUT     = 4,
    parameter jmp_mode_e         JUMP_MODE   = JMP_IMMEDIATE,
    parameter cmd_mode_e         CMD_MODE    = CMD_PERSISTENT,
    parameter bit                CATCH_FAULT = 1'b1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_STAGES-1:0]        jmp_valid,
    input logic [NUM_STAGES*ADDR_W-1:0] jmp_target,
    input logic                         cmd_valid,
    input logic                         cmd_ready,
    input logic [ADDR_W-1:0]            cmd_addr,
    input logic                         rsp_valid,
    input logic                         out_valid,
    input logic [DATA_W-1:0]            out_instr,
    input logic                         out_fault
);

    localparam int unsigned CNT_W = count_width(MAX_OUT) + 1;

    logic              first_q;
    logic              seen_q;
    logic              prev_v_q;
    logic              prev_rdy_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              was_held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q     <= 1'b1;
            seen_q      <= 1'b0;
            prev_v_q    <= 1'b0;
            prev_rdy_q  <= 1'b0;
            prev_addr_q <= '0;
            cnt_q       <= '0;
        end else begin
            first_q     <= 1'b0;
            seen_q      <= 1'b1;
            prev_v_q    <= cmd_valid;
            prev_rdy_q  <= cmd_ready;
            prev_addr_q <= cmd_addr;
            cnt_q       <= cnt_q + CNT_W'(cmd_valid && cmd_ready) - CNT_W'(rsp_valid);
        end
    end

    assign was_held = (CMD_MODE == CMD_PERSISTENT) && seen_q && prev_v_q && !prev_rdy_q;

    // R1
    reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q && (jmp_valid == '0)) |-> (cmd_valid && (cmd_addr == RESET_VEC)));

    // R6
    held_command_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        was_held |-> (cmd_valid && (cmd_addr == prev_addr_q)));

    // R5
    oldest_stage_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((JUMP_MODE == JMP_IMMEDIATE) && !was_held && jmp_valid[NUM_STAGES-1])
        |-> (cmd_addr == jmp_target[(NUM_STAGES-1)*ADDR_W +: ADDR_W]));

    // R11
    outstanding_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_OUT));

    // R11
    full_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(MAX_OUT)) |-> !cmd_valid);

    // R10
    fault_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CATCH_FAULT && out_valid && out_fault) |-> (out_instr == '0));

endmodule

bind fetch_pc_unit fetch_pc_unit_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_STAGES (NUM_STAGES),
    .RESET_VEC  (RESET_VEC),
    .MAX_OUT    (MAX_OUT),
    .JUMP_MODE  (JUMP_MODE),
    .CMD_MODE   (CMD_MODE),
    .CATCH_FAULT(CATCH_FAULT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .jmp_valid (jmp_valid),
    .jmp_target(jmp_target),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .rsp_valid (rsp_valid),
    .out_valid (out_valid),
    .out_instr (out_instr),
    .out_fault (out_fault)
);

// File: tb/fetch_pc_unit_tb.sv
module fetch_pc_unit_tb;
    import fetch_pkg::*;

    localparam int unsigned AW  = 32;
    localparam int unsigned DW  = 32;
    localparam int unsigned NS  = 4;
    localparam logic [31:0] RV  = 32'h0000_1000;
    localparam logic [31:0] TB  = 32'h0000_4000;
    // {request mask[7:4], expected winning stage[3:0]}
    localparam logic [7:0] ARB_TBL [8] = '{
        8'h10, 8'h21, 8'h31, 8'h62, 8'hF3, 8'h93, 8'h52, 8'hC3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [NS*AW-1:0] tgts;
    for (genvar i = 0; i < NS; i++) begin : g_tgt
        assign tgts[i*AW +: AW] = TB + 32'(i) * 32'h100;
    end

    // immediate / persistent / latency 1 instance
    logic [NS-1:0] jv = '0;
    logic          ready = 1'b0, rv = 1'b0, re = 1'b0;
    logic [DW-1:0] rd = '0;
    logic          cv, ov, of;
    logic [AW-1:0] ca, op;
    logic [DW-1:0] oi;

    fetch_pc_unit #(.RESET_VEC(RV)) u_dut (
        .clk(clk), .rst_n(rst_n), .jmp_valid(jv), .jmp_target(tgts),
        .cmd_valid(cv), .cmd_ready(ready), .cmd_addr(ca),
        .rsp_valid(rv), .rsp_error(re), .rsp_data(rd),
        .out_valid(ov), .out_pc(op), .out_instr(oi), .out_fault(of)
    );

    // registered / retractable / latency 2 instance
    logic [NS-1:0] r_jv = '0;
    logic          r_ready = 1'b0, r_rv = 1'b0;
    logic [DW-1:0] r_rd = '0;
    logic          r_cv, r_ov, r_of;
    logic [AW-1:0] r_ca, r_op;
    logic [DW-1:0] r_oi;

    fetch_pc_unit #(
        .RESET_VEC(RV), .LAT_MIN(2),
        .JUMP_MODE(JMP_REGISTERED), .CMD_MODE(CMD_RETRACTABLE)
    ) u_dut_reg (
        .clk(clk), .rst_n(rst_n), .jmp_valid(r_jv), .jmp_target(tgts),
        .cmd_valid(r_cv), .cmd_ready(r_ready), .cmd_addr(r_ca),
        .rsp_valid(r_rv), .rsp_error(1'b0), .rsp_data(r_rd),
        .out_valid(r_ov), .out_pc(r_op), .out_instr(r_oi), .out_fault(r_of)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        tick(); tick();
        check("R1 addr", ca, RV);
        check("R1 valid", 32'(cv), 32'd1);
        check("R1 out", 32'(ov), 32'd0);
        rst_n = 1'b1;
        ready = 1'b1;
        #1 check("R1 first cycle", ca, RV);
        tick(); check("R2 step1", ca, RV + 4);
        tick(); check("R2 step2", ca, RV + 8);
        tick(); ready = 1'b0; check("R2 step3", ca, RV + 12);
        tick(); check("R2 no accept", ca, RV + 12);

        rv = 1'b1; rd = 32'hA0A0_0001;
        tick(); check("R9 valid", 32'(ov), 32'd1);
        check("R9 pc", op, RV); check("R9 instr", oi, 32'hA0A0_0001);
        re = 1'b1; rd = 32'hDEAD_BEEF;
        tick(); check("R10 fault", 32'(of), 32'd1);
        check("R10 word", oi, 32'd0); check("R10 pc", op, RV + 4);
        re = 1'b0; rd = 32'hA0A0_0003;
        tick(); check("R10 clean", 32'(of), 32'd0); check("R9 pc3", op, RV + 8);
        rv = 1'b0;

        ready = 1'b1;
        repeat (4) tick();
        check("R11 full", 32'(cv), 32'd0);
        ready = 1'b0; rv = 1'b1; rd = 32'h1111_2222;
        tick(); check("R11 drain pc", op, RV + 12);
        repeat (3) tick();
        rv = 1'b0;
        tick(); check("R11 reopen", 32'(cv), 32'd1); check("R11 addr", ca, RV + 28);

        tick(); jv = 4'b0010;
        #1 check("R6 hold on jump", ca, RV + 28);
        tick(); jv = '0;
        check("R6 still held", ca, RV + 28); check("R6 valid", 32'(cv), 32'd1);
        ready = 1'b1;
        tick(); check("R6 resume target", ca, TB + 32'h100);
        tick(); ready = 1'b0; rv = 1'b1; rd = 32'h5555_0000;
        tick(); check("R8 dropped", 32'(ov), 32'd0);
        tick(); check("R8 kept", 32'(ov), 32'd1); check("R8 pc", op, TB + 32'h100);
        rv = 1'b0;

        for (int k = 0; k < 8; k++) begin
            ready = 1'b1;
            tick(); jv = ARB_TBL[k][7:4];
            #1 check("R5 R3 winner", ca, TB + 32'(ARB_TBL[k][3:0]) * 32'h100);
            tick(); jv = '0; ready = 1'b0; rv = 1'b1; rd = 32'(k);
            tick(); check("R8 stale", 32'(ov), 32'd0);
            tick(); check("R8 target pc", op, TB + 32'(ARB_TBL[k][3:0]) * 32'h100);
            rv = 1'b0;
        end

        // registered, retractable, two-stage response path
        r_ready = 1'b1;
        tick(); r_ready = 1'b0; r_rv = 1'b1; r_rd = 32'hC0DE_0001;
        tick(); r_rv = 1'b0; check("R9 not yet", 32'(r_ov), 32'd0);
        tick(); check("R9 lat2 valid", 32'(r_ov), 32'd1);
        check("R9 lat2 pc", r_op, RV); check("R9 lat2 instr", r_oi, 32'hC0DE_0001);
        r_ready = 1'b1; r_jv = 4'b0001;
        #1 check("R4 old addr", r_ca, RV + 4);
        tick(); r_jv = '0; r_ready = 1'b0;
        check("R4 target next", r_ca, TB);
        r_jv = 4'b0100;
        tick(); r_jv = '0;
        check("R7 replaced", r_ca, TB + 32'h200); check("R7 valid", 32'(r_cv), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule